// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block is the execute stage of a stack machine. It holds the operands in a small on-chip stack, not in named registers. Three instructions do real work. A push loads a word from data memory onto the stack. A pop stores the top word to data memory. An add replaces the two topmost words with their sum. Only push and pop carry a memory address. The add takes its operands from the stack alone, by position.

Instructions arrive on a valid/ready handshake. The data-memory port is single-port and synchronous, and a read returns its data one cycle after it is issued. For a push, the unit raises the stack pointer first and then fills the new top entry once the read data arrives. For a pop, the unit writes the current top to memory and then lowers the pointer. A push onto a full stack, or a pop or add without enough entries, does not run. It sets a sticky error flag and leaves all state as it was.

The controller has two states:
- `ST_READY` accepts an instruction.
- `ST_FILL` waits for the read data of a push.

There are three transitions:
- `ST_READY -> ST_FILL` on an accepted push that does not fault.
- `ST_FILL -> ST_READY` unconditionally on the next edge.
- `ST_READY -> ST_READY` on every other input.

Top module: `zstack_exec_unit`

## Requirements
- R1: After reset the following hold: depth is 0, `instr_ready` is 1, `err_flag` is 0, `tos_out` is 0 and `mem_en` is 0.
- R2: Opcodes on `instr_op` are 2'b00 no-op, 2'b01 push, 2'b10 pop and 2'b11 add. A no-op and an add never drive `mem_en`, and a no-op changes nothing.
- R3: A push that is accepted without a fault does the following:
  - In the cycle it is accepted, it drives `mem_en`=1, `mem_we`=0 and `mem_addr`=`instr_addr`.
  - On the next edge, depth rises by one and `instr_ready` drops.
  - On the edge after that, the returned word becomes `tos_out` and `instr_ready` returns to 1.
- R4: A pop that is accepted without a fault drives `mem_en`=1, `mem_we`=1, `mem_addr`=`instr_addr` and `mem_wdata`=`tos_out` in its acceptance cycle. On the next edge, depth falls by one and `instr_ready` stays 1.
- R5: An add that is accepted without a fault replaces the top two entries with their sum modulo 2^16, one edge later. Depth falls by one.
- R6: A push when depth is 8 sets `err_flag`, drives no memory access, and leaves depth and stack contents unchanged.
- R7: A pop at depth 0, or an add at depth below 2, sets `err_flag`, drives no memory access, and leaves depth and stack contents unchanged.
- R8: `err_flag` stays set until reset.
- R9: An instruction is accepted only while `instr_ready` is 1. Valid instructions that are presented while a push read is outstanding are ignored.
- R10: `tos_out` shows the top entry, or 0 when the stack is empty. `depth_out` shows the entry count, from 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_op | input | 2 | Opcode (see R2) |
| instr_addr | input | 8 | Memory address for push/pop |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after a read |
| tos_out | output | 16 | Current top of stack |
| depth_out | output | 4 | Number of stack entries |
| err_flag | output | 1 | Sticky overflow/underflow flag |

## Verification
The results of an instruction are due at three different times, counted from the edge that accepts it:
- Memory strobes, address and write data are combinational, so they are due in the acceptance cycle. The bench samples them at the falling edge before that edge.
- Pops, adds, faults and no-ops update depth, top and the flag one edge after acceptance.
- A push updates depth and drops ready after one edge, and delivers its word as the top after a second edge.

The bench samples each of these at the falling edge that follows the edge on which it is due. It waits for ready again before it presents the next instruction.

// File: rtl/zstack_pkg.sv
package zstack_pkg;

    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_ADD  = 2'b11
    } zs_op_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_FILL  = 1'b1
    } zs_state_e;

endpackage

// File: rtl/zstack_regfile.sv
module zstack_regfile #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx_a,
    input  logic [IW-1:0] rd_idx_b,
    output logic [W-1:0]  rd_data_a,
    output logic [W-1:0]  rd_data_b
);

    logic [W-1:0] entries [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                entries[g] <= wr_data;
            end
        end
    end

    assign rd_data_a = entries[rd_idx_a];
    assign rd_data_b = entries[rd_idx_b];

endmodule

// File: rtl/zstack_guard.sv
module zstack_guard #(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    op,
    input  logic [PW-1:0] depth,
    output logic          fault
);
    import zstack_pkg::*;

    always_comb begin
        unique case (zs_op_e'(op))
            OP_PUSH: fault = (depth == PW'(DEPTH));
            OP_POP:  fault = (depth == '0);
            OP_ADD:  fault = (depth < PW'(2));
            default: fault = 1'b0;
        endcase
    end

endmodule

// File: rtl/zstack_ctrl.sv
module zstack_ctrl #(
    parameter int W     = 16,
    parameter int AW    = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [1:0]    instr_op,
    input  logic [AW-1:0] instr_addr,
    input  logic          fault,
    input  logic [W-1:0]  top_data,
    input  logic [W-1:0]  next_data,
    input  logic [W-1:0]  mem_rdata,
    output logic          instr_ready,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          rf_we,
    output logic [IW-1:0] rf_idx,
    output logic [W-1:0]  rf_data,
    output logic [IW-1:0] top_idx,
    output logic [IW-1:0] next_idx,
    output logic [PW-1:0] depth,
    output logic          err_flag
);
    import zstack_pkg::*;

    zs_state_e     state_q, state_d;
    logic [PW-1:0] depth_d;
    logic          err_d;
    logic [PW-1:0] depth_m1, depth_m2;
    logic          accept;

    assign depth_m1 = depth - PW'(1);
    assign depth_m2 = depth - PW'(2);
    assign top_idx  = depth_m1[IW-1:0];
    assign next_idx = depth_m2[IW-1:0];
    assign accept   = instr_valid && (state_q == ST_READY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_READY;
            depth    <= '0;
            err_flag <= 1'b0;
        end else begin
            state_q  <= state_d;
            depth    <= depth_d;
            err_flag <= err_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        depth_d = depth;
        err_d   = err_flag;
        unique case (state_q)
            ST_READY: begin
                if (accept) begin
                    if (fault) begin
                        err_d = 1'b1;
                    end else begin
                        unique case (zs_op_e'(instr_op))
                            OP_PUSH: begin
                                depth_d = depth + PW'(1);
                                state_d = ST_FILL;
                            end
                            OP_POP:  depth_d = depth_m1;
                            OP_ADD:  depth_d = depth_m1;
                            default: ;
                        endcase
                    end
                end
            end
            ST_FILL: state_d = ST_READY;
            default: state_d = ST_READY;
        endcase
    end

    // outputs
    always_comb begin
        instr_ready = 1'b0;
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = instr_addr;
        mem_wdata   = top_data;
        rf_we       = 1'b0;
        rf_idx      = top_idx;
        rf_data     = mem_rdata;
        unique case (state_q)
            ST_READY: begin
                instr_ready = 1'b1;
                if (accept && !fault) begin
                    unique case (zs_op_e'(instr_op))
                        OP_PUSH: mem_en = 1'b1;
                        OP_POP: begin
                            mem_en = 1'b1;
                            mem_we = 1'b1;
                        end
                        OP_ADD: begin
                            rf_we   = 1'b1;
                            rf_idx  = next_idx;
                            rf_data = top_data + next_data;
                        end
                        default: ;
                    endcase
                end
            end
            ST_FILL: begin
                rf_we = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/zstack_exec_unit.sv
module zstack_exec_unit #(
    parameter int W     = 16,
    parameter int AW    = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    output logic          instr_ready,
    input  logic [1:0]    instr_op,
    input  logic [AW-1:0] instr_addr,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    output logic [W-1:0]  tos_out,
    output logic [PW-1:0] depth_out,
    output logic          err_flag
);

    logic          fault;
    logic          rf_we;
    logic [IW-1:0] rf_idx, top_idx, next_idx;
    logic [W-1:0]  rf_data, top_data, next_data;
    logic [PW-1:0] depth;

    zstack_guard #(.DEPTH(DEPTH)) u_guard (
        .op    (instr_op),
        .depth (depth),
        .fault (fault)
    );

    zstack_ctrl #(.W(W), .AW(AW), .DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .instr_addr  (instr_addr),
        .fault       (fault),
        .top_data    (top_data),
        .next_data   (next_data),
        .mem_rdata   (mem_rdata),
        .instr_ready (instr_ready),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .rf_we       (rf_we),
        .rf_idx      (rf_idx),
        .rf_data     (rf_data),
        .top_idx     (top_idx),
        .next_idx    (next_idx),
        .depth       (depth),
        .err_flag    (err_flag)
    );

    zstack_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (rf_we),
        .wr_idx    (rf_idx),
        .wr_data   (rf_data),
        .rd_idx_a  (top_idx),
        .rd_idx_b  (next_idx),
        .rd_data_a (top_data),
        .rd_data_b (next_data)
    );

    assign depth_out = depth;
    assign tos_out   = (depth == '0) ? '0 : top_data;

endmodule

// File: rtl/zstack_exec_unit_checker.sv
module zstack_exec_unit_checker #(
    parameter int W     = 16,
    parameter int AW    = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic          instr_ready,
    input logic [1:0]    instr_op,
    input logic [AW-1:0] instr_addr,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [W-1:0]  mem_wdata,
    input logic [W-1:0]  mem_rdata,
    input logic [W-1:0]  tos_out,
    input logic [PW-1:0] depth_out,
    input logic          err_flag
);

    logic take;
    assign take = instr_valid && instr_ready;

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        depth_out <= PW'(DEPTH)); // R10

    AST_PUSH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_op == 2'b01 && depth_out < PW'(DEPTH))
        |-> (mem_en && !mem_we && mem_addr == instr_addr)); // R3

    AST_PUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_op == 2'b01 && depth_out < PW'(DEPTH))
        |=> (!instr_ready && depth_out == $past(depth_out) + 1'b1)); // R3

    AST_POP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_op == 2'b10 && depth_out != '0)
        |-> (mem_en && mem_we && mem_addr == instr_addr && mem_wdata == tos_out)); // R4

    AST_ADD_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_op == 2'b11 && depth_out >= PW'(2))
        |=> (depth_out == $past(depth_out) - 1'b1)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_op == 2'b01 && depth_out == PW'(DEPTH))
        |=> (err_flag && $stable(depth_out))); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_op == 2'b10 && depth_out == '0)
        |=> (err_flag && $stable(depth_out))); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R8

    AST_QUIET_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_op == 2'b11 || instr_op == 2'b00 || !take) |-> !mem_en); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_ready |=> instr_ready); // R9

endmodule

bind zstack_exec_unit zstack_exec_unit_checker #(.W(W), .AW(AW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/zstack_exec_unit_bench.sv
`timescale 1ns/1ps
module zstack_exec_unit_bench;

    localparam int W = 16, AW = 8, DEPTH = 8, PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic          instr_ready;
    logic [1:0]    instr_op = 2'b00;
    logic [AW-1:0] instr_addr = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata = '0;
    logic [W-1:0]  tos_out;
    logic [PW-1:0] depth_out;
    logic          err_flag;

    int checks = 0;
    int failures = 0;

    logic [W-1:0] ram [1 << AW];
    logic [W-1:0] m_ram [1 << AW];
    logic [W-1:0] m_stk [DEPTH];
    int           m_depth = 0;
    logic         m_err = 1'b0;

    always #10 clk = ~clk;

    zstack_exec_unit u_zstack_exec_unit (.*);

    // single-port RAM, one-cycle read latency
    always @(posedge clk) begin
        if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= ram[mem_addr];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] m_top();
        return (m_depth == 0) ? '0 : m_stk[m_depth-1];
    endfunction

    function automatic bit m_fault(input logic [1:0] op);
        return (op == 2'b01 && m_depth == DEPTH) || (op == 2'b10 && m_depth == 0) ||
               (op == 2'b11 && m_depth < 2);
    endfunction

    task automatic check_state(input string tag);
        check(depth_out == PW'(m_depth), {tag, " depth R10"}, 32'(depth_out), 32'(m_depth));
        check(tos_out == m_top(), {tag, " tos R10"}, 32'(tos_out), 32'(m_top()));
        check(err_flag == m_err, {tag, " err R8"}, 32'(err_flag), 32'(m_err));
    endtask

    // present one instruction; optionally hold valid high through a push stall
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input bit hold);
        bit f;
        @(negedge clk);
        while (!instr_ready) @(negedge clk);
        instr_valid = 1'b1; instr_op = op; instr_addr = a;
        #1;
        f = m_fault(op);
        if (f || op == 2'b00 || op == 2'b11)
            check(!mem_en, "no mem access R2 R6 R7", 32'(mem_en), 0);
        else if (op == 2'b01)
            check(mem_en && !mem_we && mem_addr == a, "push read R3", {mem_en, mem_we, mem_addr}, {2'b10, a});
        else
            check(mem_en && mem_we && mem_addr == a && mem_wdata == m_top(), "pop write R4",
                  32'(mem_wdata), 32'(m_top()));
        @(posedge clk);
        @(negedge clk);
        if (f) begin
            m_err = 1'b1;
        end else if (op == 2'b01) begin
            m_depth++;
            m_stk[m_depth-1] = m_ram[a];
            check(!instr_ready, "push stall R3", 32'(instr_ready), 0);
            check(depth_out == PW'(m_depth), "push ptr first R3", 32'(depth_out), 32'(m_depth));
            if (hold) instr_op = 2'b10; else instr_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check(instr_ready, "push done R3 R9", 32'(instr_ready), 1);
        end else if (op == 2'b10) begin
            m_ram[a] = m_top();
            m_depth--;
            check(instr_ready, "pop no stall R4", 32'(instr_ready), 1);
        end else if (op == 2'b11) begin
            m_stk[m_depth-2] = m_stk[m_depth-1] + m_stk[m_depth-2];
            m_depth--;
        end
        instr_valid = 1'b0;
        check_state("after op");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << AW); i++) begin
            ram[i] = W'(i * 16'h1357 + 3);
            m_ram[i] = ram[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(instr_ready && !mem_en, "reset ready R1", {instr_ready, mem_en}, 2'b10);
        check_state("reset R1");

        // directed: underflow cases
        issue(2'b10, 8'h10, 0);               // pop empty R7
        issue(2'b00, 8'h00, 0);               // no-op R2
        issue(2'b01, 8'h05, 0);
        issue(2'b11, 8'h00, 0);               // add with one entry R7
        // R9: valid held through the push stall with a pop opcode, must be ignored
        issue(2'b01, 8'hFF, 1);
        // wrap-around add R5
        ram[8'h20] = 16'hFFFF; m_ram[8'h20] = 16'hFFFF;
        ram[8'h21] = 16'h0003; m_ram[8'h21] = 16'h0003;
        issue(2'b01, 8'h20, 0);
        issue(2'b01, 8'h21, 0);
        issue(2'b11, 8'h00, 0);
        check(tos_out == 16'h0002, "add wrap R5", 32'(tos_out), 32'h2);
        // fill to full and overflow R6
        while (m_depth < DEPTH) issue(2'b01, 8'(m_depth), 0);
        issue(2'b01, 8'h33, 0);
        // pop to memory then reload R4
        issue(2'b10, 8'h40, 0);
        issue(2'b01, 8'h40, 0);

        // reset clears sticky flag R1 R8
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_depth = 0; m_err = 1'b0;
        @(negedge clk);
        check_state("re-reset R1");

        for (int n = 0; n < 400; n++) begin
            logic [1:0] op;
            int r;
            r = $urandom_range(0, 9);
            op = (r < 4) ? 2'b01 : (r < 7) ? 2'b11 : (r < 9) ? 2'b10 : 2'b00;
            issue(op, 8'($urandom_range(0, 255)), bit'($urandom_range(0, 1)));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule